// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the CPU-side sequencer that moves an 8-bit core into and out of an interrupt service routine. It owns the 16-bit program counter, the flag register and the stack pointer of a byte-wide stack kept in data memory. During normal execution the core updates the program counter and flags through write ports. An enabled request is accepted only at an instruction boundary. Acceptance starts a dispatch of fixed length. The dispatch saves the context on the stack, clears the flags and jumps into the interrupt table at the vector supplied by the interrupt controller.

A return-from-interrupt, signalled by the decoder at an instruction boundary, pops the saved context back. If an enabled request is still waiting when the return completes, a new dispatch begins at once, and no normal instruction runs in between. The stack memory sits outside the block. The block drives a write strobe, a read strobe, an address and write data, and it takes read data combinationally in the same cycle.

Top module: `irq_seq_top`

## Requirements
- R1: A request is accepted only in a cycle where the sequencer is idle (`busy`=0), `instr_done`=1, `irq_req`=1 and the global enable bit (flag bit 0) is 1. In any other cycle the request changes nothing, and `busy` stays 0.
- R2: An accepted dispatch keeps `busy` high for exactly 13 cycles. `disp_cnt` counts 0 to 12 during those cycles, and normal running resumes in the next cycle.
- R3: Dispatch cycles 0, 1 and 2 each write one byte with `stk_we`=1 at `stk_addr`=`sp`. The bytes are the upper PC byte, then the lower PC byte, then the flags. `sp` rises by one after each write, for a net gain of 3.
- R4: From dispatch cycle 3 onward the flag register reads 0, which also clears the global enable bit.
- R5: `irq_ack` pulses for one cycle in dispatch cycle 3, and `irq_vector` is sampled in that cycle. From cycle 4 the PC reads {8'h00, vector}.
- R6: With `reti_start`=1 and `instr_done`=1 while idle, a return starts, and it takes precedence over a request in the same cycle. The return runs 3 cycles with `stk_re`=1 at `stk_addr`=`sp`-1. Those cycles restore the flags, then the lower PC byte, then the upper PC byte, and `sp` drops by one each cycle.
- R7: If `irq_req`=1 and the restored global enable bit is 1 when the last return cycle ends, a dispatch starts in the following cycle, and `busy` does not fall in between.
- R8: `core_pc_wr` and `core_flag_wr` update PC and flags at the next clock edge while idle. They are ignored while `busy`=1.
- R9: After reset the PC, flags and `sp` are 0, `busy`=0, and no strobe or acknowledge is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Pending unmasked request from the interrupt controller |
| irq_vector | input | 8 | Table offset for the pending request |
| irq_ack | output | 1 | One-cycle acknowledge in the vector-sampling cycle |
| instr_done | input | 1 | Current instruction finishes in this cycle |
| reti_start | input | 1 | Finishing instruction is a return-from-interrupt |
| core_pc_wr | input | 1 | Core program-counter write enable |
| core_pc_val | input | 16 | Core program-counter write value |
| core_flag_wr | input | 1 | Core flag write enable |
| core_flag_val | input | 8 | Core flag write value |
| stk_we | output | 1 | Stack byte write strobe |
| stk_re | output | 1 | Stack byte read strobe |
| stk_addr | output | 8 | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, valid in the same cycle |
| pc | output | 16 | Program counter |
| flags | output | 8 | Flag register, bit 0 is the global enable |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Dispatch or return in progress |
| disp_cnt | output | 4 | Dispatch cycle index, 0 outside a dispatch |

## Verification
A mistake in the phase counter shows up at the ports within a cycle. It moves the write strobe, the acknowledge or the end of `busy`, and it changes how many cycles `busy` stays high. A wrong byte selection or stack-pointer step produces a wrong write address or write value during the first three dispatch cycles. A fault in the pop path stays hidden until the return completes, and then it shows up as a wrong PC or wrong flags. A gap between a return and a chained dispatch appears as a single low cycle on `busy`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_DISP = 2'd1,
        ST_RET  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/irq_seq_accept.sv
module irq_seq_accept (
    input  logic in_run,
    input  logic ret_last,
    input  logic instr_done,
    input  logic reti_start,
    input  logic irq_req,
    input  logic gie,
    output logic go_ret,
    output logic go_disp,
    output logic chain_disp
);
    logic boundary;

    always_comb begin
        boundary   = in_run && instr_done;
        // a return at the boundary wins over a new request
        go_ret     = boundary && reti_start;
        go_disp    = boundary && !reti_start && irq_req && gie;
        chain_disp = ret_last && irq_req && gie;
    end
endmodule

// File: rtl/irq_seq_stack_port.sv
module irq_seq_stack_port
    import irq_seq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int SP_W   = 8,
    parameter int CNT_W  = 4,
    parameter int N_PUSH = 3
) (
    input  seq_st_e           st,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [SP_W-1:0]   sp,
    input  logic [2*DW-1:0]   pc,
    input  logic [DW-1:0]     flags,
    output logic              we,
    output logic              re,
    output logic [SP_W-1:0]   addr,
    output logic [DW-1:0]     wdata
);
    localparam logic [CNT_W-1:0] C_PUSH = CNT_W'(N_PUSH);
    localparam logic [CNT_W-1:0] C_HI   = CNT_W'(0);
    localparam logic [CNT_W-1:0] C_LO   = CNT_W'(1);

    always_comb begin
        we    = 1'b0;
        re    = 1'b0;
        addr  = sp;
        wdata = '0;
        if (st == ST_DISP && cnt < C_PUSH) begin
            we = 1'b1;
            if (cnt == C_HI) begin
                wdata = pc[2*DW-1:DW];
            end else if (cnt == C_LO) begin
                wdata = pc[DW-1:0];
            end else begin
                wdata = flags;
            end
        end else if (st == ST_RET) begin
            re   = 1'b1;
            addr = sp - SP_W'(1);
        end
    end
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
    import irq_seq_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SP_W      = 8,
    parameter int DISP_LEN  = 13,
    parameter int ACK_SLOT  = 3,
    parameter int GIE_BIT   = 0,
    parameter int SP_INIT   = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        irq_req,
    input  logic [DW-1:0]               irq_vector,
    output logic                        irq_ack,
    input  logic                        instr_done,
    input  logic                        reti_start,
    input  logic                        core_pc_wr,
    input  logic [2*DW-1:0]             core_pc_val,
    input  logic                        core_flag_wr,
    input  logic [DW-1:0]               core_flag_val,
    output logic                        stk_we,
    output logic                        stk_re,
    output logic [SP_W-1:0]             stk_addr,
    output logic [DW-1:0]               stk_wdata,
    input  logic [DW-1:0]               stk_rdata,
    output logic [2*DW-1:0]             pc,
    output logic [DW-1:0]               flags,
    output logic [SP_W-1:0]             sp,
    output logic                        busy,
    output logic [$clog2(DISP_LEN)-1:0] disp_cnt
);
    localparam int PC_W   = 2 * DW;
    localparam int CNT_W  = $clog2(DISP_LEN);
    localparam int N_PUSH = 3;
    localparam int N_POP  = 3;

    localparam logic [CNT_W-1:0] C_LAST    = CNT_W'(DISP_LEN - 1);
    localparam logic [CNT_W-1:0] C_FCLR    = CNT_W'(N_PUSH - 1);
    localparam logic [CNT_W-1:0] C_ACK     = CNT_W'(ACK_SLOT);
    localparam logic [CNT_W-1:0] C_POP_F   = CNT_W'(0);
    localparam logic [CNT_W-1:0] C_POP_LO  = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_POP_END = CNT_W'(N_POP - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  pc;
        logic [DW-1:0]    flags;
        logic [SP_W-1:0]  sp;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic go_ret, go_disp, chain_disp;
    logic push_we, pop_re;
    logic disp_w;

    assign disp_w = (r_q.st == ST_DISP);

    irq_seq_accept i_accept (
        .in_run     (r_q.st == ST_RUN),
        .ret_last   (r_q.st == ST_RET && r_q.cnt == C_POP_END),
        .instr_done (instr_done),
        .reti_start (reti_start),
        .irq_req    (irq_req),
        .gie        (r_q.flags[GIE_BIT]),
        .go_ret     (go_ret),
        .go_disp    (go_disp),
        .chain_disp (chain_disp)
    );

    irq_seq_stack_port #(
        .DW     (DW),
        .SP_W   (SP_W),
        .CNT_W  (CNT_W),
        .N_PUSH (N_PUSH)
    ) i_stack_port (
        .st    (r_q.st),
        .cnt   (r_q.cnt),
        .sp    (r_q.sp),
        .pc    (r_q.pc),
        .flags (r_q.flags),
        .we    (push_we),
        .re    (pop_re),
        .addr  (stk_addr),
        .wdata (stk_wdata)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (core_pc_wr) begin
                    r_d.pc = core_pc_val;
                end
                if (core_flag_wr) begin
                    r_d.flags = core_flag_val;
                end
                if (go_ret) begin
                    r_d.st  = ST_RET;
                    r_d.cnt = '0;
                end else if (go_disp) begin
                    r_d.st  = ST_DISP;
                    r_d.cnt = '0;
                end
            end
            ST_DISP: begin
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (push_we) begin
                    r_d.sp = r_q.sp + SP_W'(1);
                end
                if (r_q.cnt == C_FCLR) begin
                    r_d.flags = '0;
                end
                if (r_q.cnt == C_ACK) begin
                    r_d.pc = {{DW{1'b0}}, irq_vector};
                end
                if (r_q.cnt == C_LAST) begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                end
            end
            ST_RET: begin
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (pop_re) begin
                    r_d.sp = r_q.sp - SP_W'(1);
                end
                if (r_q.cnt == C_POP_F) begin
                    r_d.flags = stk_rdata;
                end else if (r_q.cnt == C_POP_LO) begin
                    r_d.pc[DW-1:0] = stk_rdata;
                end else begin
                    r_d.pc[PC_W-1:DW] = stk_rdata;
                end
                if (r_q.cnt == C_POP_END) begin
                    r_d.cnt = '0;
                    r_d.st  = chain_disp ? ST_DISP : ST_RUN;
                end
            end
            default: begin
                r_d.st  = ST_RUN;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_RUN;
            r_q.cnt   <= '0;
            r_q.pc    <= '0;
            r_q.flags <= '0;
            r_q.sp    <= SP_W'(SP_INIT);
        end else begin
            r_q <= r_d;
        end
    end

    assign stk_we   = push_we;
    assign stk_re   = pop_re;
    assign pc       = r_q.pc;
    assign flags    = r_q.flags;
    assign sp       = r_q.sp;
    assign busy     = (r_q.st != ST_RUN);
    assign irq_ack  = disp_w && (r_q.cnt == C_ACK);
    assign disp_cnt = disp_w ? r_q.cnt : '0;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int DW       = 8,
    parameter int SP_W     = 8,
    parameter int DISP_LEN = 13,
    parameter int ACK_SLOT = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        busy,
    input logic                        in_disp,
    input logic [$clog2(DISP_LEN)-1:0] disp_cnt,
    input logic                        irq_ack,
    input logic                        stk_we,
    input logic                        stk_re,
    input logic [SP_W-1:0]             stk_addr,
    input logic [SP_W-1:0]             sp,
    input logic [2*DW-1:0]             pc,
    input logic [DW-1:0]               flags
);
    localparam int CNT_W = $clog2(DISP_LEN);
    localparam logic [CNT_W-1:0] C_LAST = CNT_W'(DISP_LEN - 1);
    localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(ACK_SLOT);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_disp && disp_cnt != C_LAST) |=> (in_disp && disp_cnt == $past(disp_cnt) + CNT_W'(1))); // R2
    AST_DISP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (in_disp && disp_cnt == C_LAST) |=> !busy); // R2
    AST_PUSH_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |-> (stk_addr == sp && in_disp)); // R3
    AST_PUSH_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (sp == $past(sp) + SP_W'(1))); // R3
    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_disp && disp_cnt == C_ACK) |-> (flags == '0)); // R4
    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (pc[2*DW-1:DW] == '0 && !irq_ack)); // R5
    AST_POP_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        stk_re |=> (sp == $past(sp) - SP_W'(1))); // R6
    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!stk_we && !stk_re && !irq_ack)); // R9
endmodule

bind irq_seq_top irq_seq_chk #(
    .DW       (DW),
    .SP_W     (SP_W),
    .DISP_LEN (DISP_LEN),
    .ACK_SLOT (ACK_SLOT)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .in_disp  (disp_w),
    .disp_cnt (disp_cnt),
    .irq_ack  (irq_ack),
    .stk_we   (stk_we),
    .stk_re   (stk_re),
    .stk_addr (stk_addr),
    .sp       (sp),
    .pc       (pc),
    .flags    (flags)
);

// File: tb/test_irq_seq_top.sv
module test_irq_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vector = 8'h00;
    logic        irq_ack;
    logic        instr_done = 1'b0;
    logic        reti_start = 1'b0;
    logic        core_pc_wr = 1'b0;
    logic [15:0] core_pc_val = 16'h0;
    logic        core_flag_wr = 1'b0;
    logic [7:0]  core_flag_val = 8'h0;
    logic        stk_we, stk_re;
    logic [7:0]  stk_addr, stk_wdata, stk_rdata;
    logic [15:0] pc;
    logic [7:0]  flags, sp;
    logic        busy;
    logic [3:0]  disp_cnt;

    logic [7:0]  mem [0:255];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference model
    int m_mode = 0;   // 0 run, 1 dispatch, 2 return
    int m_cnt = 0;
    int m_pc = 0;
    int m_flags = 0;
    int m_sp = 0;
    int m_stack[$];

    always #10 clk = ~clk;

    irq_seq_top i_irq_seq_top (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vector(irq_vector),
        .irq_ack(irq_ack), .instr_done(instr_done), .reti_start(reti_start),
        .core_pc_wr(core_pc_wr), .core_pc_val(core_pc_val),
        .core_flag_wr(core_flag_wr), .core_flag_val(core_flag_val),
        .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .pc(pc), .flags(flags),
        .sp(sp), .busy(busy), .disp_cnt(disp_cnt)
    );

    assign stk_rdata = mem[stk_addr];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    end

    always @(posedge clk) begin
        if (stk_we) mem[stk_addr] <= stk_wdata;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_pc = 0; m_flags = 0; m_sp = 0;
            m_stack.delete();
        end else begin
            case (m_mode)
                0: begin
                    int old_gie;
                    old_gie = m_flags & 1;
                    if (core_pc_wr) m_pc = core_pc_val;
                    if (core_flag_wr) m_flags = core_flag_val;
                    if (instr_done && reti_start) begin
                        m_mode = 2; m_cnt = 0;
                    end else if (instr_done && irq_req && old_gie == 1) begin
                        m_mode = 1; m_cnt = 0;
                    end
                end
                1: begin
                    if (m_cnt == 0) m_stack.push_back((m_pc >> 8) & 255);
                    if (m_cnt == 1) m_stack.push_back(m_pc & 255);
                    if (m_cnt == 2) begin
                        m_stack.push_back(m_flags);
                        m_flags = 0;
                    end
                    if (m_cnt < 3) m_sp = (m_sp + 1) & 255;
                    if (m_cnt == 3) m_pc = irq_vector;
                    if (m_cnt == 12) begin
                        m_mode = 0; m_cnt = 0;
                    end else m_cnt++;
                end
                default: begin
                    int v;
                    v = m_stack.pop_back();
                    m_sp = (m_sp + 255) & 255;
                    if (m_cnt == 0) m_flags = v;
                    if (m_cnt == 1) m_pc = (m_pc & 16'hff00) | v;
                    if (m_cnt == 2) begin
                        m_pc = (m_pc & 16'h00ff) | (v << 8);
                        m_cnt = 0;
                        m_mode = (irq_req && (m_flags & 1) == 1) ? 1 : 0;
                    end else m_cnt++;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 pc vs model", pc, m_pc);
            chk("R4 flags vs model", flags, m_flags);
            chk("R3 sp vs model", sp, m_sp);
            chk("R2 busy vs model", busy, m_mode != 0);
            chk("R2 disp_cnt vs model", disp_cnt, (m_mode == 1) ? m_cnt : 0);
            chk("R5 irq_ack vs model", irq_ack, (m_mode == 1 && m_cnt == 3));
            chk("R3 stk_we vs model", stk_we, (m_mode == 1 && m_cnt < 3));
            chk("R6 stk_re vs model", stk_re, (m_mode == 2));
            if (m_mode == 1 && m_cnt < 3) begin
                chk("R3 push addr", stk_addr, m_sp);
                chk("R3 push data", stk_wdata,
                    (m_cnt == 0) ? ((m_pc >> 8) & 255) : (m_cnt == 1) ? (m_pc & 255) : m_flags);
            end
            if (m_mode == 2) chk("R6 pop addr", stk_addr, (m_sp + 255) & 255);
        end
    end

    task automatic core_write(logic [15:0] p, logic [7:0] f);
        core_pc_wr = 1; core_pc_val = p; core_flag_wr = 1; core_flag_val = f;
        @(negedge clk);
        core_pc_wr = 0; core_flag_wr = 0;
    endtask

    // pulse instr_done, then count busy cycles; core writes are driven throughout (R8)
    task automatic boundary(bit ret, bit drop_req, output int n_busy);
        instr_done = 1; reti_start = ret;
        @(negedge clk);
        instr_done = 0; reti_start = 0;
        n_busy = 0;
        core_pc_wr = 1; core_pc_val = 16'hBEEF; core_flag_wr = 1; core_flag_val = 8'hFF;
        while (busy) begin
            n_busy++;
            if (irq_ack && drop_req) irq_req = 0;
            @(negedge clk);
        end
        core_pc_wr = 0; core_flag_wr = 0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset pc", pc, 0);
        chk("R9 reset flags", flags, 0);
        chk("R9 reset sp", sp, 0);
        chk("R9 reset busy/strobes", {busy, stk_we, stk_re, irq_ack}, 0);
        rst_n = 1;
        @(negedge clk);

        // R8 writes while idle
        core_write(16'h1234, 8'h01);
        chk("R8 idle pc write", pc, 16'h1234);
        chk("R8 idle flag write", flags, 8'h01);

        // R1 request without boundary
        irq_req = 1; irq_vector = 8'h20;
        repeat (4) @(negedge clk);
        chk("R1 no boundary no dispatch", busy, 0);

        // first dispatch
        boundary(0, 1, n);
        chk("R2 dispatch length", n, 13);
        chk("R5 vector pc", pc, 16'h0020);
        chk("R4 flags cleared", flags, 0);
        chk("R3 sp after push", sp, 3);
        chk("R3 pushed pc hi", mem[0], 8'h12);
        chk("R3 pushed pc lo", mem[1], 8'h34);
        chk("R3 pushed flags", mem[2], 8'h01);
        chk("R8 writes ignored while busy", pc, 16'h0020);

        // return
        core_write(16'h0040, 8'h00);
        boundary(1, 0, n);
        chk("R6 return length", n, 3);
        chk("R6 restored pc", pc, 16'h1234);
        chk("R6 restored flags", flags, 8'h01);
        chk("R6 sp after pop", sp, 0);

        // R1 global enable off
        core_write(16'h2000, 8'h00);
        irq_req = 1; irq_vector = 8'h30;
        instr_done = 1; @(negedge clk); instr_done = 0;
        repeat (2) @(negedge clk);
        chk("R1 gie off no dispatch", busy, 0);

        // R7 chained dispatch after return
        core_write(16'h2000, 8'h81);
        boundary(0, 0, n);
        chk("R2 second dispatch length", n, 13);
        chk("R5 vector 30", pc, 16'h0030);
        core_write(16'h0031, 8'h00);
        // request still pending: return then straight into dispatch
        boundary(1, 1, n);
        chk("R7 return chained into dispatch", n, 16);
        chk("R7 pc after chained dispatch", pc, 16'h0030);
        chk("R7 sp after chained dispatch", sp, 3);
        chk("R7 pushed restored flags", mem[2], 8'h81);
        boundary(1, 0, n);
        chk("R6 restored after chain pc", pc, 16'h2000);
        chk("R6 restored after chain flags", flags, 8'h81);

        // nested dispatch inside an ISR that re-enables interrupts
        irq_req = 1; irq_vector = 8'h44;
        boundary(0, 1, n);
        core_write(16'h0050, 8'h01);
        irq_req = 1; irq_vector = 8'h48;
        boundary(0, 1, n);
        chk("R3 nested sp", sp, 6);
        chk("R5 nested vector", pc, 16'h0048);
        chk("R3 nested pushed lo", mem[4], 8'h50);
        boundary(1, 0, n);
        chk("R6 nested return pc", pc, 16'h0050);
        boundary(1, 0, n);
        chk("R6 outer return pc", pc, 16'h2000);
        chk("R6 outer return sp", sp, 0);

        // R6 return wins over request at the same boundary
        core_write(16'h3000, 8'h01);
        irq_req = 1; irq_vector = 8'h50;
        boundary(0, 0, n);   // enter, request kept high
        core_write(16'h0051, 8'h01);
        instr_done = 1; reti_start = 1;
        @(negedge clk);
        instr_done = 0; reti_start = 0;
        chk("R6 return has precedence", stk_re, 1);
        irq_req = 0;
        repeat (20) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule